// File: doc/BRIEF.md
# Chainable Up-Counting Timer Pair

This block holds two identical up-counting timers that can drive each other. Each timer has a clock divider, a counter that returns to zero after reaching a programmable top value, and one compare channel whose reference level is high while the count is below the compare value. A master selector chooses what the timer places on its trigger output: nothing, a one-clock pulse on every wrap, or the compare reference level. A slave controller picks one trigger input and decides how the counter advances. The counter can run from the divided system clock, count the rising edges of the selected trigger, or run from the divided clock only while that trigger is high.

Trigger input 0 of each timer is wired to the trigger output of the other timer. Inputs 1 to N_EXT come from the `ext_trig` pins. This lets one timer act as a clock divider for its peer, with the peer advancing once per wrap. It also lets one timer gate its peer, with the peer counting only while the compare reference is high. Software programs the timers through a single write port. `wr_sel` selects the timer and `wr_addr` selects the field.

Top module: `tmr_chain`

## Requirements
- R1: While `rst_n` is low, and right after it is released, both counters read 0. Every update flag, trigger output and compare reference is 0.
- R2: A write with `wr_en` high goes to the timer chosen by `wr_sel`. The field is set by `wr_addr`: 0 = control, 1 = divider, 2 = top value, 3 = compare value. Control bits are: bit 0 enable, bits 3:1 master select, bits 6:4 slave select, bits 9:7 trigger select. A written value is used from the clock edge after the write.
- R3: With slave select 000, or any code other than 101 or 111, an enabled counter advances once every (divider+1) clock cycles.
- R4: A count step taken while the counter is greater than or equal to the top value sets the counter to 0. The update flag is high for exactly the one cycle in which the counter first reads 0.
- R5: While enable is 0, the counter and the divider hold their values and no update is produced.
- R6: The compare reference is high whenever the counter is below the compare value and low otherwise. It follows the counter with no extra cycle of delay.
- R7: Trigger output by master select: 1xx gives the compare reference level; 010 gives a copy of the update pulse; every other code gives 0.
- R8: Trigger select 000 takes the peer timer's trigger output. Codes 001 to 011 take `ext_trig[0]` to `ext_trig[2]`. Higher codes select a constant 0.
- R9: With slave select 111, the counter advances by exactly one for each rising edge of the selected trigger, and the count changes on the next clock edge. A trigger held high adds no further counts, and the divider is not used.
- R10: With slave select 101, the counter advances from the divided clock only while the selected trigger is high. The divider freezes while the trigger is low.
- R11: When the master timer uses master select 010 and its peer uses slave select 111 with trigger select 000, the peer counts exactly one step per master update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Target timer (0 or 1) |
| wr_addr | input | 2 | Field address |
| wr_data | input | CNT_W | Write data |
| ext_trig | input | N_EXT | External trigger lines shared by both timers |
| cnt0 | output | CNT_W | Counter of timer 0 |
| cnt1 | output | CNT_W | Counter of timer 1 |
| upd0 | output | 1 | Update pulse of timer 0 |
| upd1 | output | 1 | Update pulse of timer 1 |
| tout0 | output | 1 | Trigger output of timer 0 |
| tout1 | output | 1 | Trigger output of timer 1 |
| ref0 | output | 1 | Compare reference of timer 0 |
| ref1 | output | 1 | Compare reference of timer 1 |

## Verification
The free-running mode is driven with divide ratios of 1 and 3 and with top values of 0, 1 and 5. One of these runs lowers the top value below the current count, which shows whether the wrap test is an equality or an ordering. External edge counting uses trigger pulses one, two and three cycles wide. This separates edge counting from level counting and also shows whether an unselected line leaks through. Gated mode uses gate windows that start and stop in the middle of a divide period. Both chained arrangements are run: counting update pulses, and gating by the compare level. In the update-pulse chain, the slave's count change is compared with the number of master pulses seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_TOP  = 2'd2;
    localparam logic [1:0] ADDR_CMP  = 2'd3;

    localparam logic [2:0] MSEL_NONE   = 3'b000;
    localparam logic [2:0] MSEL_UPDATE = 3'b010;

    localparam logic [2:0] SSEL_FREE   = 3'b000;
    localparam logic [2:0] SSEL_GATED  = 3'b101;
    localparam logic [2:0] SSEL_EXTCLK = 3'b111;

    typedef struct packed {
        logic [2:0] tsel;
        logic [2:0] ssel;
        logic [2:0] msel;
        logic       en;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] ratio,
    output logic         tick
);

    typedef struct packed {
        logic [W-1:0] phase;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.phase >= ratio);
        if (tick) begin
            st_d.phase = '0;
        end else if (run) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: after a tick the phase restarts, so a back-to-back tick needs ratio 0
    assert_div_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || ratio == '0));

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tmr_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [N_IN-1:0] tin,
    input  logic [2:0]      tsel,
    input  logic [2:0]      ssel,
    input  logic            div_tick,
    output logic            div_run,
    output logic            step,
    output logic            trig_lvl
);

    typedef struct packed {
        logic prev;
    } sl_st_t;

    sl_st_t st_d, st_q;
    logic   rise;

    always_comb begin
        trig_lvl = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (tsel == 3'(i)) begin
                trig_lvl = tin[i];
            end
        end
        rise = trig_lvl && !st_q.prev;

        st_d      = st_q;
        st_d.prev = trig_lvl;

        unique case (ssel)
            SSEL_EXTCLK: begin
                div_run = 1'b0;
                step    = en && rise;
            end
            SSEL_GATED: begin
                div_run = en && trig_lvl;
                step    = div_tick;
            end
            default: begin
                div_run = en;
                step    = div_tick;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: one rising edge yields one step, never two in a row
    assert_one_step_per_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ssel == SSEL_EXTCLK) |=> !(step && ssel == SSEL_EXTCLK));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_IN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [N_IN-1:0]  tin,
    output logic [CNT_W-1:0] cnt,
    output logic             upd,
    output logic             tout,
    output logic             cref
);

    typedef struct packed {
        tmr_ctrl_t        ctl;
        logic [CNT_W-1:0] ratio;
        logic [CNT_W-1:0] top;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] cnt;
        logic             upd;
        logic             tout;
        logic             cref;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     div_tick;
    logic     div_run;
    logic     step;
    logic     trig_lvl;
    logic     wrap;

    tmr_divider #(.W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .ratio (st_q.ratio),
        .tick  (div_tick)
    );

    tmr_slave_ctrl #(.N_IN(N_IN)) u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.ctl.en),
        .tin      (tin),
        .tsel     (st_q.ctl.tsel),
        .ssel     (st_q.ctl.ssel),
        .div_tick (div_tick),
        .div_run  (div_run),
        .step     (step),
        .trig_lvl (trig_lvl)
    );

    always_comb begin
        st_d = st_q;

        wrap = step && (st_q.cnt >= st_q.top);
        if (step) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
        st_d.upd  = wrap;
        st_d.cref = st_d.cnt < st_q.cmp;

        if (st_q.ctl.msel[2]) begin
            st_d.tout = st_d.cref;
        end else if (st_q.ctl.msel == MSEL_UPDATE) begin
            st_d.tout = wrap;
        end else begin
            st_d.tout = 1'b0;
        end

        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: st_d.ctl   = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_DIV:  st_d.ratio = wr_data;
                ADDR_TOP:  st_d.top   = wr_data;
                default:   st_d.cmp   = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign upd  = st_q.upd;
    assign tout = st_q.tout;
    assign cref = st_q.cref;

    // R4: the update pulse lines up with the counter reading zero
    assert_upd_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> (st_q.cnt == '0));

    // R5: a disabled timer keeps its count
    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl.en |=> $stable(st_q.cnt));

    // R7: in update mode the trigger output mirrors the update flag
    assert_tout_is_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.msel == MSEL_UPDATE) |=> (st_q.tout == st_q.upd));

    // R10: a closed gate freezes the counter
    assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.ssel == SSEL_GATED && !trig_lvl) |=> $stable(st_q.cnt));

endmodule

// File: rtl/tmr_chain.sv
module tmr_chain #(
    parameter int CNT_W = 16,
    parameter int N_EXT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [N_EXT-1:0] ext_trig,
    output logic [CNT_W-1:0] cnt0,
    output logic [CNT_W-1:0] cnt1,
    output logic             upd0,
    output logic             upd1,
    output logic             tout0,
    output logic             tout1,
    output logic             ref0,
    output logic             ref1
);

    localparam int N_IN  = N_EXT + 1;
    localparam int N_TMR = 2;

    logic [CNT_W-1:0] cnt_v  [N_TMR];
    logic [N_TMR-1:0] upd_v;
    logic [N_TMR-1:0] tout_v;
    logic [N_TMR-1:0] ref_v;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        logic [N_IN-1:0] tin;
        logic            sel_hit;

        assign tin     = {ext_trig, tout_v[N_TMR-1-g]};
        assign sel_hit = wr_en && (wr_sel == 1'(g));

        tmr_unit #(.CNT_W(CNT_W), .N_IN(N_IN)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_hit),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .tin     (tin),
            .cnt     (cnt_v[g]),
            .upd     (upd_v[g]),
            .tout    (tout_v[g]),
            .cref    (ref_v[g])
        );
    end

    assign cnt0  = cnt_v[0];
    assign cnt1  = cnt_v[1];
    assign upd0  = upd_v[0];
    assign upd1  = upd_v[1];
    assign tout0 = tout_v[0];
    assign tout1 = tout_v[1];
    assign ref0  = ref_v[0];
    assign ref1  = ref_v[1];

    // R1: outputs are quiet on the first cycle after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (upd_v == '0 && tout_v == '0));

endmodule

// File: tb/test_tmr_chain.sv
module test_tmr_chain;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   ext_trig = '0;
    logic [W-1:0] cnt0, cnt1;
    logic         upd0, upd1, tout0, tout1, ref0, ref1;

    always #5 clk = ~clk;

    tmr_chain #(.CNT_W(W), .N_EXT(3)) i_tmr_chain (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .ext_trig(ext_trig),
        .cnt0(cnt0), .cnt1(cnt1), .upd0(upd0), .upd1(upd1),
        .tout0(tout0), .tout1(tout1), .ref0(ref0), .ref1(ref1)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "R1";

    typedef struct {
        logic [W-1:0] c0, c1;
        logic u0, u1, g0, g1, r0, r1;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // expected-behaviour model state
    logic [W-1:0] m_div[2], m_top[2], m_cmp[2], m_cnt[2], m_ph[2];
    logic         m_en[2], m_prev[2], m_upd[2], m_tout[2], m_ref[2];
    logic [2:0]   m_ms[2], m_ss[2], m_ts[2];

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ctrl(input bit en, input logic [2:0] ms,
                                          input logic [2:0] ss, input logic [2:0] ts);
        return W'({ts, ss, ms, en});
    endfunction

    // driver side: predict the next visible state and push it
    task automatic predict();
        exp_t e;
        logic old_t[2];
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin
                m_div[t] = '0; m_top[t] = '0; m_cmp[t] = '0; m_cnt[t] = '0;
                m_ph[t] = '0; m_en[t] = 0; m_prev[t] = 0; m_upd[t] = 0;
                m_tout[t] = 0; m_ref[t] = 0; m_ms[t] = '0; m_ss[t] = '0; m_ts[t] = '0;
            end
        end else begin
            old_t[0] = m_tout[0];
            old_t[1] = m_tout[1];
            for (int t = 0; t < 2; t++) begin
                logic trig, rise, step, wrap;
                if (m_ts[t] == 3'd0) trig = old_t[1-t];
                else if (m_ts[t] <= 3'd3) trig = ext_trig[m_ts[t]-3'd1];
                else trig = 1'b0;
                rise = trig && !m_prev[t];
                m_prev[t] = trig;
                step = 1'b0;
                if (m_ss[t] == 3'b111) begin
                    step = m_en[t] && rise;
                end else if (m_en[t] && (m_ss[t] != 3'b101 || trig)) begin
                    if (m_ph[t] >= m_div[t]) begin
                        m_ph[t] = '0;
                        step = 1'b1;
                    end else begin
                        m_ph[t] = m_ph[t] + 1'b1;
                    end
                end
                wrap = step && (m_cnt[t] >= m_top[t]);
                if (step) m_cnt[t] = wrap ? '0 : m_cnt[t] + 1'b1;
                m_upd[t] = wrap;
                m_ref[t] = m_cnt[t] < m_cmp[t];
                m_tout[t] = m_ms[t][2] ? m_ref[t] : (m_ms[t] == 3'b010 ? wrap : 1'b0);
            end
            if (wr_en) begin
                int t = int'(wr_sel);
                case (wr_addr)
                    2'd0: begin
                        m_en[t] = wr_data[0]; m_ms[t] = wr_data[3:1];
                        m_ss[t] = wr_data[6:4]; m_ts[t] = wr_data[9:7];
                    end
                    2'd1: m_div[t] = wr_data;
                    2'd2: m_top[t] = wr_data;
                    default: m_cmp[t] = wr_data;
                endcase
            end
        end
        e.c0 = m_cnt[0]; e.c1 = m_cnt[1];
        e.u0 = m_upd[0]; e.u1 = m_upd[1];
        e.g0 = m_tout[0]; e.g1 = m_tout[1];
        e.r0 = m_ref[0]; e.r1 = m_ref[1];
        e.tag = phase;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) predict();

    // monitor side: pop and compare away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "cnt0", cnt0, e.c0);
            chk(e.tag, "cnt1", cnt1, e.c1);
            chk(e.tag, "upd0", W'(upd0), W'(e.u0));
            chk(e.tag, "upd1", W'(upd1), W'(e.u1));
            chk(e.tag, "tout0", W'(tout0), W'(e.g0));
            chk(e.tag, "tout1", W'(tout1), W'(e.g1));
            chk(e.tag, "ref0", W'(ref0), W'(e.r0));
            chk(e.tag, "ref1", W'(ref1), W'(e.r1));
        end
    end

    task automatic wr(input bit sel, input logic [1:0] addr, input logic [W-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int bitn, input int hi, input int lo);
        ext_trig[bitn] = 1'b1;
        idle(hi);
        ext_trig[bitn] = 1'b0;
        idle(lo);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        logic [W-1:0] start1;

        // R1: reset state
        idle(3);
        chk("R1", "cnt0 in reset", cnt0, '0);
        chk("R1", "cnt1 in reset", cnt1, '0);
        chk("R1", "upd0|tout0|ref0 in reset", W'({upd0, tout0, ref0}), '0);
        rst_n = 1'b1;
        idle(2);

        // R2: per-timer field writes, timer 1 divider does not touch timer 0
        phase = "R2";
        wr(0, 2'd1, 16'd2);
        wr(0, 2'd2, 16'd5);
        wr(1, 2'd1, 16'd7);
        wr(0, 2'd0, ctrl(1, 3'b000, 3'b000, 3'd0));

        // R3: free run, divide by 3, top 5
        phase = "R3";
        idle(40);
        wr(0, 2'd0, ctrl(1, 3'b000, 3'b011, 3'd0));
        idle(12);

        // R6/R7: compare reference, level mode and an unused master code
        phase = "R6";
        wr(0, 2'd3, 16'd3);
        wr(0, 2'd0, ctrl(1, 3'b100, 3'b000, 3'd0));
        idle(30);
        phase = "R7";
        wr(0, 2'd0, ctrl(1, 3'b011, 3'b000, 3'd0));
        idle(12);
        wr(0, 2'd0, ctrl(1, 3'b010, 3'b000, 3'd0));
        idle(20);

        // R5: disabled timer freezes
        phase = "R5";
        wr(0, 2'd0, ctrl(0, 3'b010, 3'b000, 3'd0));
        idle(10);
        wr(0, 2'd0, ctrl(1, 3'b010, 3'b000, 3'd0));
        idle(7);

        // R4: top lowered below count, then top 0 with divider 0
        phase = "R4";
        wr(0, 2'd2, 16'd1);
        idle(15);
        wr(0, 2'd1, 16'd0);
        wr(0, 2'd2, 16'd0);
        idle(6);
        wr(0, 2'd0, ctrl(0, 3'b000, 3'b000, 3'd0));

        // R9: edge counting from ext_trig[0]
        phase = "R9";
        wr(1, 2'd1, 16'd0);
        wr(1, 2'd2, 16'd9);
        wr(1, 2'd0, ctrl(1, 3'b000, 3'b111, 3'd1));
        pulse(0, 1, 2);
        pulse(0, 2, 1);
        pulse(0, 3, 3);
        pulse(0, 1, 1);
        chk("R9", "cnt1 after four edges", cnt1, 16'd4);

        // R8: other lines, an unselected line and a code above the range
        phase = "R8";
        pulse(1, 2, 2);
        chk("R8", "unselected line ignored", cnt1, 16'd4);
        wr(1, 2'd0, ctrl(1, 3'b000, 3'b111, 3'd3));
        pulse(2, 1, 2);
        pulse(2, 1, 2);
        chk("R8", "ext_trig[2] counted", cnt1, 16'd6);
        wr(1, 2'd0, ctrl(1, 3'b000, 3'b111, 3'd5));
        pulse(0, 1, 1);
        pulse(1, 1, 1);
        pulse(2, 1, 1);
        chk("R8", "code 5 selects nothing", cnt1, 16'd6);

        // R10: gated counting on ext_trig[1], divide by 2
        phase = "R10";
        wr(1, 2'd1, 16'd1);
        wr(1, 2'd0, ctrl(1, 3'b000, 3'b101, 3'd2));
        pulse(1, 7, 5);
        pulse(1, 4, 3);
        pulse(1, 9, 2);

        // R11: timer 0 updates clock timer 1
        phase = "R11";
        wr(0, 2'd1, 16'd1);
        wr(0, 2'd2, 16'd3);
        wr(1, 2'd2, 16'd200);
        wr(1, 2'd0, ctrl(1, 3'b000, 3'b111, 3'd0));
        wr(0, 2'd0, ctrl(1, 3'b010, 3'b000, 3'd0));
        idle(3);
        start1 = cnt1;
        pulses = 0;
        for (int k = 0; k < 80; k++) begin
            if (upd0) pulses++;
            @(negedge clk);
        end
        chk("R11", "slave steps vs master updates", cnt1 - start1, W'(pulses));
        chk("R11", "master produced updates", W'(pulses > 5), 16'd1);

        // R11: timer 0 compare level gates timer 1
        wr(0, 2'd1, 16'd0);
        wr(0, 2'd2, 16'd5);
        wr(0, 2'd3, 16'd2);
        wr(0, 2'd0, ctrl(1, 3'b100, 3'b000, 3'd0));
        wr(1, 2'd1, 16'd0);
        wr(1, 2'd0, ctrl(1, 3'b000, 3'b101, 3'd0));
        idle(40);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule